// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

This block measures the frequency of the clock it runs on by counting that clock against a slow, free-running reference square wave. A start request arms the meter. The reference input passes through a two-flop synchronizer, and its rising edges are detected in the measured domain. A window down-counter is preloaded two steps above its counting target and waits for the reference to step it down to that target. Counting therefore always begins exactly on a reference edge, and the window spans a fixed number of whole reference periods.

While the window is open, the measured clock drives a divide-by-N prescaler. Each prescaler event advances a saturating event counter. When the window expires, the count is latched and converted to hertz with a round-to-nearest-0.1 MHz formula, and a one-cycle done pulse is issued. With the default divisor of 177 and a window of 58 periods of an 8192 Hz reference, one count is worth very nearly 25 kHz. Four counts therefore make one 0.1 MHz step.

Top module: `freq_meter`

## Requirements
- R1: After reset, busy_o, done_o, sat_o, count_o and freq_hz_o are all zero.
- R2: A start_i seen while idle raises busy_o on the next cycle and clears count_o, freq_hz_o and sat_o to zero. A start_i seen while busy has no effect on the measurement or its result.
- R3: After a start, counting opens on the second synchronized rising edge of ref_i. At that point the window counter, which was preloaded with WINDOW_TICKS+1, reaches WINDOW_TICKS-1. Counting closes on the edge that finds the window counter at zero, so the window lasts exactly WINDOW_TICKS reference periods.
- R4: The prescaler reloads with PRESCALE_DIV-1 and produces one event per PRESCALE_DIV measured cycles inside the window. For a reference period of P measured cycles, count_o therefore equals floor(WINDOW_TICKS*P/PRESCALE_DIV).
- R5: done_o is high for exactly one cycle, in the same cycle that busy_o falls. count_o, freq_hz_o and sat_o are valid in that cycle and hold their values until the next accepted start.
- R6: freq_hz_o equals floor((count_o+2)/4) multiplied by STEP_HZ.
- R7: Raw counts of 4k-1 and 4k+1 both report exactly k*STEP_HZ.
- R8: The event counter stops at 2^CNT_W-1 instead of wrapping. sat_o is then set, together with done_o.
- R9: Only rising edges of ref_i matter. The duty cycle of ref_i does not change the result.
- R10: Every measurement starts from a zero count and a fresh prescaler phase, so a result does not depend on earlier measurements, including saturated ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measured clock; the whole block runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Measurement request, accepted only while idle |
| ref_i | input | 1 | Asynchronous reference square wave |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse when results become valid |
| count_o | output | CNT_W | Latched raw prescaled event count |
| freq_hz_o | output | FREQ_W | Latched frequency in hertz, rounded to STEP_HZ |
| sat_o | output | 1 | Event counter saturated during the last window |

## Verification
The bench goes after window alignment. A meter that opened on the first edge, or closed one edge late, would be off by a whole reference period's worth of counts, and the exact floor(W*P/DIV) check would catch that. Reference periods of 38 and 39 cycles give raw counts of 63 and 65, which straddle the rounding boundary. Bad rounding would report 1.5 or 1.7 MHz instead of 1.6 MHz for both. A long reference period drives the counter past its maximum, where a wrapping counter would report a small count with no flag. A short run right after it shows any count, phase or flag left over from the saturated run. A start issued mid-window, and reference duty cycles of one cycle and of period minus one, would disturb a design that restarted while busy or counted levels instead of edges.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARM    = 2'd1,
    ST_RUN    = 2'd2,
    ST_FINISH = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_tick_sync.sv
module fm_tick_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic pulse_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ref_i};
      prev_q <= sync_q[1];
    end
  end

  assign pulse_o = sync_q[1] & ~prev_q;

  // a rising edge yields a single-cycle pulse
  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/fm_prescaler.sv
module fm_prescaler #(
  parameter int unsigned DIV = 177
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic evt_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] RELOAD = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               pre_q <= RELOAD;
        else if (clr_i)            pre_q <= RELOAD;
        else if (en_i) begin
          if (pre_q == '0)         pre_q <= RELOAD;
          else                     pre_q <= pre_q - 1'b1;
        end
      end
      assign evt_o = en_i && (pre_q == '0);

      // events are at least DIV cycles apart
      assert_evt_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |=> !evt_o);
    end else begin : g_bypass
      assign evt_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/fm_event_counter.sv
module fm_event_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      sat_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      sat_o <= 1'b0;
    end else if (inc_i) begin
      if (cnt_o == CNT_MAX) sat_o <= 1'b1;
      else                  cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));
  assert_sat_at_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> cnt_o == CNT_MAX);
endmodule

// File: rtl/fm_window.sv
module fm_window #(
  parameter int unsigned TICKS = 58
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic at_open_o,
  output logic at_zero_o
);
  localparam int unsigned WW = $clog2(TICKS + 2);
  localparam logic [WW-1:0] PRELOAD = WW'(TICKS + 1);
  localparam logic [WW-1:0] OPEN_AT = WW'(TICKS);

  logic [WW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (load_i) win_q <= PRELOAD;
    else if (dec_i)  win_q <= win_q - 1'b1;
  end

  // the edge that takes the counter from TICKS to TICKS-1 opens the window
  assign at_open_o = (win_q == OPEN_AT);
  assign at_zero_o = (win_q == '0);

  assert_win_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= PRELOAD);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> win_q != '0);
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 177,
  parameter int unsigned WINDOW_TICKS = 58,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned FREQ_W       = 32,
  parameter int unsigned STEP_HZ      = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ref_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [FREQ_W-1:0] freq_hz_o,
  output logic              sat_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [FREQ_W-1:0] STEP    = FREQ_W'(STEP_HZ);

  fm_state_e         state_q;
  logic              tick;
  logic              at_open, at_zero;
  logic              win_load, win_dec;
  logic              run, evt;
  logic [CNT_W-1:0]  ev_cnt;
  logic              ev_sat;
  logic [CNT_W:0]    cnt_rnd;
  logic [FREQ_W-1:0] freq_d;

  fm_tick_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .pulse_o(tick)
  );

  assign win_load = (state_q == ST_IDLE) && start_i;
  assign win_dec  = tick && ((state_q == ST_ARM) || ((state_q == ST_RUN) && !at_zero));
  assign run      = (state_q == ST_RUN);

  fm_window #(.TICKS(WINDOW_TICKS)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (win_load),
    .dec_i    (win_dec),
    .at_open_o(at_open),
    .at_zero_o(at_zero)
  );

  fm_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (win_load),
    .en_i  (run),
    .evt_o (evt)
  );

  fm_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (win_load),
    .inc_i (evt),
    .cnt_o (ev_cnt),
    .sat_o (ev_sat)
  );

  // round to nearest step: four counts per step
  assign cnt_rnd = {1'b0, ev_cnt} + (CNT_W+1)'(2);
  assign freq_d  = FREQ_W'(cnt_rnd >> 2) * STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done_o    <= 1'b0;
      count_o   <= '0;
      freq_hz_o <= '0;
      sat_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_ARM;
          count_o   <= '0;
          freq_hz_o <= '0;
          sat_o     <= 1'b0;
        end
        ST_ARM:  if (tick && at_open) state_q <= ST_RUN;
        ST_RUN:  if (tick && at_zero) state_q <= ST_FINISH;
        ST_FINISH: begin
          count_o   <= ev_cnt;
          freq_hz_o <= freq_d;
          sat_o     <= ev_sat;
          done_o    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && count_o == '0 && !sat_o));
  assert_busy_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !done_o && state_q != ST_FINISH) |=> busy_o);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_fall_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_result_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(count_o) && $stable(freq_hz_o) && $stable(sat_o)));
  assert_sat_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> count_o == CNT_MAX);
endmodule

// File: tb/freq_meter_test.sv
module freq_meter_test;
  localparam int unsigned DIV   = 3;
  localparam int unsigned WT    = 5;
  localparam int unsigned CW    = 10;
  localparam int unsigned FW    = 32;
  localparam int unsigned STEP  = 100000;
  localparam int unsigned CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ref_sig = 1'b0;
  logic          busy, done, sat;
  logic [CW-1:0] count;
  logic [FW-1:0] freq;

  int n_chk  = 0;
  int n_fail = 0;
  int per    = 20;
  int hi     = 10;
  int ph     = 0;

  always #2 clk = ~clk;

  freq_meter #(
    .PRESCALE_DIV(DIV), .WINDOW_TICKS(WT), .CNT_W(CW), .FREQ_W(FW), .STEP_HZ(STEP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_i(ref_sig),
    .busy_o(busy), .done_o(done), .count_o(count), .freq_hz_o(freq), .sat_o(sat)
  );

  // reference square wave, period per cycles, high for hi cycles
  initial begin
    forever begin
      @(negedge clk);
      ph = (ph + 1 >= per) ? 0 : ph + 1;
      ref_sig = (ph < hi);
    end
  end

  function automatic longint exp_raw(int p);
    return longint'(WT) * p / DIV;
  endfunction
  function automatic longint exp_cnt(int p);
    return (exp_raw(p) > CMAX) ? CMAX : exp_raw(p);
  endfunction
  function automatic longint exp_freq(longint c);
    return ((c + 2) / 4) * STEP;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic measure(int p, int h, bit poke, string req, output longint got_freq);
    longint ec;
    int n;
    per = p; hi = h;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(count == '0 && freq == '0 && sat == 1'b0, "R2", "results cleared", count, 0);
    if (poke) begin
      repeat (p * 3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", "busy kept on start while busy", busy, 1);
    end
    n = 0;
    while (!done && n < (WT + 6) * p + 100) begin
      @(negedge clk);
      n++;
    end
    ec = exp_cnt(p);
    check(done == 1'b1, "R5", "done seen", done, 1);
    check(busy == 1'b0, "R5", "busy low with done", busy, 0);
    check(longint'(count) == ec, req, "count", count, ec);
    check(longint'(freq) == exp_freq(ec), "R6", "freq", freq, exp_freq(ec));
    check(sat == (exp_raw(p) > CMAX), "R8", "sat flag", sat, exp_raw(p) > CMAX);
    got_freq = longint'(freq);
    @(negedge clk);
    check(done == 1'b0, "R5", "done one cycle", done, 0);
    check(longint'(count) == ec, "R5", "count held", count, ec);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    longint f0, f1;
    int p, h;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && sat == 0, "R1", "flags after reset", {busy, done, sat}, 0);
    check(count == '0 && freq == '0, "R1", "results after reset", count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    measure(30, 15, 1'b0, "R3", f0);        // R3 R4: 5*30/3 = 50
    measure(31, 10, 1'b0, "R4", f0);        // 155/3 = 51
    measure(38, 19, 1'b0, "R7", f0);        // raw 63 = 4*16-1
    measure(39, 19, 1'b0, "R7", f1);        // raw 65 = 4*16+1
    check(f0 == 16 * STEP && f1 == 16 * STEP, "R7", "rounding both sides", f1, 16 * STEP);
    measure(50, 1, 1'b0, "R9", f0);         // narrow high
    measure(50, 49, 1'b0, "R9", f1);        // wide high
    check(f0 == f1, "R9", "duty independent", f1, f0);
    measure(60, 30, 1'b1, "R2", f0);        // start while busy ignored
    measure(700, 350, 1'b0, "R8", f0);      // raw 1166 saturates at 1023
    measure(100, 50, 1'b0, "R10", f0);      // fresh after saturation
    for (int i = 0; i < 10; i++) begin
      p = $urandom_range(400, 16);
      h = $urandom_range(p - 1, 1);
      measure(p, h, 1'b0, "R4", f0);
    end
    summary();
  end
endmodule